// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This unit carries out the shift and rotate group of a 16-bit integer datapath. It works on a byte or a word operand and returns the result together with the carry, zero, sign and overflow flags. Seven operations are supported: left shift (two code points that behave the same), logical right shift, arithmetic right shift, plain rotates in both directions, and rotates in both directions that pass through the carry flag. In those last two, the carry acts as one extra bit above the operand's top bit.

The distance is either a fixed 1 or the low five bits of a count-register value. A control input picks between the two. The caller presents the operand, the control fields and the current flags together with a one-cycle start pulse. On the next clock edge the unit registers the result and the new flags, and raises done for one cycle. The registered outputs then hold until the next start.

The whole multi-bit operation is worked out combinationally in the start cycle, so the latency is always one cycle, whatever the count.

Top module: `sru_top`

## Requirements
- R1: A start pulse causes done_o to be 1 in exactly the following cycle only. result_o and the flag outputs change only in that cycle and otherwise hold their values.
- R2: When cnt_sel_i is 0 the count is 1. When cnt_sel_i is 1 the count is cl_i[4:0], and cl_i[7:5] has no effect.
- R3: Op codes 0 and 7 both shift left and insert zeros at bit 0. cf_o is the last bit moved out of the top bit, so a left shift by 3 equals multiplication by 8 within the width.
- R4: Op code 1 shifts right and inserts zeros at the top bit. cf_o is the last bit moved out of bit 0, so a right shift by 3 equals unsigned division by 8.
- R5: Op code 2 shifts right, refills the top bit with its original value, and leaves the last bit moved out of bit 0 in cf_o.
- R6: Op code 3 rotates left (top bit into bit 0) with cf_o equal to bit 0 of the result. Op code 4 rotates right (bit 0 into top bit) with cf_o equal to the result's top bit.
- R7: Op codes 5 (left) and 6 (right) rotate the width+1 bit value formed by cf_i above the operand. cf_o takes the carry position after the rotate.
- R8: When wide_i is 0 the operation works on operand_i[7:0], bit 7 is the top bit, and result_o[15:8] is 0. When wide_i is 1 it works on all 16 bits and bit 15 is the top bit.
- R9: For the shift op codes (0, 1, 2, 7) with a nonzero count, zf_o is 1 exactly when the result is zero, and sf_o equals the result's top bit.
- R10: For the rotate op codes (3 to 6), zf_o and sf_o equal zf_i and sf_i.
- R11: With a count of 1, of_o is computed as follows. For the left op codes (0, 3, 5, 7) it is the result's top bit XOR cf_o. For the right op codes (1, 2, 4, 6) it is the operand's top bit XOR the result's top bit.
- R12: With a count above 1, of_o is 0.
- R13: With a count of 0, result_o is the operand limited to the selected width, and cf_o, zf_o, sf_o and of_o equal their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to perform an operation |
| op_i | input | 3 | Operation code (0 SHL, 1 SHR, 2 SAR, 3 ROL, 4 ROR, 5 RCL, 6 RCR, 7 SAL) |
| wide_i | input | 1 | 0 selects byte, 1 selects word |
| cnt_sel_i | input | 1 | 0 selects a count of 1, 1 selects cl_i |
| cl_i | input | 8 | Count register value; only bits 4:0 are used |
| operand_i | input | 16 | Value to shift or rotate |
| cf_i | input | 1 | Carry flag before the operation |
| zf_i | input | 1 | Zero flag before the operation |
| sf_i | input | 1 | Sign flag before the operation |
| of_i | input | 1 | Overflow flag before the operation |
| done_o | output | 1 | One-cycle pulse marking valid outputs |
| result_o | output | 16 | Registered result |
| cf_o | output | 1 | Carry flag after the operation |
| zf_o | output | 1 | Zero flag after the operation |
| sf_o | output | 1 | Sign flag after the operation |
| of_o | output | 1 | Overflow flag after the operation |

## Verification
Every result and flag is due one clock after the start pulse, in the same cycle as done_o, because a single register stage sits between the inputs and the outputs. The bench drives the inputs and the start pulse on a falling edge and checks all outputs on the next falling edge, after the capturing rising edge. One falling edge later it checks that done_o has dropped and that the outputs have held. The checker's properties use the same one-cycle offset with |=> from the start cycle.

// File: rtl/sru_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes op codes are the 3-bit values used at the top-level port.
package sru_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_SAL = 3'd7
    } sru_op_e;

    // True for the four rotate codes, which leave ZF and SF alone.
    function automatic logic op_is_rotate(sru_op_e op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
    endfunction

    // True for codes that move bits toward the top.
    function automatic logic op_is_left(sru_op_e op);
        return (op == OP_SHL) || (op == OP_SAL) || (op == OP_ROL) || (op == OP_RCL);
    endfunction

endpackage

// File: rtl/sru_count.sv
// Count selection: a fixed distance of one, or the low CNT_W bits of the
// count-register value. Assumes CL_W >= CNT_W.
module sru_count #(
    parameter int CL_W  = 8,
    parameter int CNT_W = 5
) (
    input  logic             cnt_sel_i,
    input  logic [CL_W-1:0]  cl_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Pick the distance and drop the count-register bits above CNT_W.
    always_comb begin
        cnt_o = cnt_sel_i ? cl_i[CNT_W-1:0] : CNT_W'(1);
    end

endmodule

// File: rtl/sru_datapath.sv
// Combinational shift/rotate engine. It applies up to 2**CNT_W-1 single-bit
// steps in a chain and keeps the last bit moved out as the new carry.
// Assumes DATA_W is even; the narrow mode uses the low DATA_W/2 bits.
module sru_datapath
    import sru_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  sru_op_e           op_i,
    input  logic              wide_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              cf_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o
);

    localparam int HALF_W    = DATA_W / 2;
    localparam int MAX_STEPS = (1 << CNT_W) - 1;
    localparam logic [DATA_W-1:0] MASK_W = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] MASK_B = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] TOP_W  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] TOP_B  = {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] top_bit;

    // Width-dependent mask and top-bit position.
    always_comb begin
        mask    = wide_i ? MASK_W : MASK_B;
        top_bit = wide_i ? TOP_W  : TOP_B;
    end

    // Chain of single-bit steps, each enabled while its index is below the count.
    always_comb begin
        logic [DATA_W-1:0] v;
        logic              c;
        logic              hi;
        logic              lo;
        v  = operand_i & mask;
        c  = cf_i;
        hi = 1'b0;
        lo = 1'b0;
        for (int i = 0; i < MAX_STEPS; i++) begin
            if (i < int'(cnt_i)) begin
                hi = |(v & top_bit);
                lo = v[0];
                unique case (op_i)
                    OP_SHL, OP_SAL: begin
                        c = hi;
                        v = (v << 1) & mask;
                    end
                    OP_SHR: begin
                        c = lo;
                        v = v >> 1;
                    end
                    OP_SAR: begin
                        c = lo;
                        v = (v >> 1) | (hi ? top_bit : '0);
                    end
                    OP_ROL: begin
                        c = hi;
                        v = ((v << 1) & mask) | DATA_W'(hi);
                    end
                    OP_ROR: begin
                        c = lo;
                        v = (v >> 1) | (lo ? top_bit : '0);
                    end
                    OP_RCL: begin
                        v = ((v << 1) & mask) | DATA_W'(c);
                        c = hi;
                    end
                    OP_RCR: begin
                        v = (v >> 1) | (c ? top_bit : '0);
                        c = lo;
                    end
                    default: begin
                        c = c;
                        v = v;
                    end
                endcase
            end
        end
        result_o = v;
        cf_o     = c;
    end

endmodule

// File: rtl/sru_flags.sv
// Flag generation. A zero count passes all flags through; rotates keep ZF
// and SF; OF is defined only for a count of one and is 0 otherwise.
// Assumes result_i is already limited to the selected width.
module sru_flags
    import sru_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  sru_op_e           op_i,
    input  logic              wide_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              cf_new_i,
    input  logic              cf_i,
    input  logic              zf_i,
    input  logic              sf_i,
    input  logic              of_i,
    output logic              cf_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o
);

    localparam int HALF_W = DATA_W / 2;

    logic res_msb;
    logic opd_msb;

    // Top bit of result and operand at the selected width.
    always_comb begin
        res_msb = wide_i ? result_i[DATA_W-1]  : result_i[HALF_W-1];
        opd_msb = wide_i ? operand_i[DATA_W-1] : operand_i[HALF_W-1];
    end

    // Flag selection by count, op class and direction.
    always_comb begin
        if (cnt_i == '0) begin
            cf_o = cf_i;
            zf_o = zf_i;
            sf_o = sf_i;
            of_o = of_i;
        end else begin
            cf_o = cf_new_i;
            if (op_is_rotate(op_i)) begin
                zf_o = zf_i;
                sf_o = sf_i;
            end else begin
                zf_o = (result_i == '0);
                sf_o = res_msb;
            end
            if (cnt_i != CNT_W'(1))
                of_o = 1'b0;
            else if (op_is_left(op_i))
                of_o = res_msb ^ cf_new_i;
            else
                of_o = opd_msb ^ res_msb;
        end
    end

endmodule

// File: rtl/sru_top.sv
// Shift/rotate unit top. Computes the operation in the start cycle and
// registers result and flags, with done_o pulsing one cycle after start_i.
// Assumes start_i is a single-cycle pulse; outputs hold between operations.
module sru_top
    import sru_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CL_W   = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic              cnt_sel_i,
    input  logic [CL_W-1:0]   cl_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              cf_i,
    input  logic              zf_i,
    input  logic              sf_i,
    input  logic              of_i,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o
);

    sru_op_e           op;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] dp_result;
    logic              dp_cf;
    logic              nx_cf, nx_zf, nx_sf, nx_of;

    // Decode the raw op code into the shared enum.
    always_comb begin
        op = sru_op_e'(op_i);
    end

    sru_count #(.CL_W(CL_W), .CNT_W(CNT_W)) u_count (
        .cnt_sel_i (cnt_sel_i),
        .cl_i      (cl_i),
        .cnt_o     (cnt)
    );

    sru_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
        .op_i      (op),
        .wide_i    (wide_i),
        .cnt_i     (cnt),
        .operand_i (operand_i),
        .cf_i      (cf_i),
        .result_o  (dp_result),
        .cf_o      (dp_cf)
    );

    sru_flags #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_flags (
        .op_i      (op),
        .wide_i    (wide_i),
        .cnt_i     (cnt),
        .operand_i (operand_i),
        .result_i  (dp_result),
        .cf_new_i  (dp_cf),
        .cf_i      (cf_i),
        .zf_i      (zf_i),
        .sf_i      (sf_i),
        .of_i      (of_i),
        .cf_o      (nx_cf),
        .zf_o      (nx_zf),
        .sf_o      (nx_sf),
        .of_o      (nx_of)
    );

    // Done pulse: high for the one cycle after a start.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= start_i;
    end

    // Output registers: load on start, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            cf_o     <= 1'b0;
            zf_o     <= 1'b0;
            sf_o     <= 1'b0;
            of_o     <= 1'b0;
        end else if (start_i) begin
            result_o <= dp_result;
            cf_o     <= nx_cf;
            zf_o     <= nx_zf;
            sf_o     <= nx_sf;
            of_o     <= nx_of;
        end
    end

endmodule

// File: rtl/sru_checker.sv
// Protocol and flag properties for sru_top, attached by bind.
// Assumes the default 16-bit data width and 5-bit count.
module sru_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [2:0]  op_i,
    input logic        wide_i,
    input logic        cnt_sel_i,
    input logic [7:0]  cl_i,
    input logic [15:0] operand_i,
    input logic        zf_i,
    input logic        sf_i,
    input logic        done_o,
    input logic [15:0] result_o,
    input logic        zf_o,
    input logic        sf_o,
    input logic        of_o
);

    logic [4:0] eff_cnt;
    logic       is_rot;

    // Effective count and op class, recomputed from the ports.
    always_comb begin
        eff_cnt = cnt_sel_i ? cl_i[4:0] : 5'd1;
        is_rot  = (op_i >= 3'd3) && (op_i <= 3'd6);
    end

    a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o) && $stable(zf_o) && $stable(sf_o) && $stable(of_o));

    a_r8_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !wide_i |=> result_o[15:8] == 8'h00);

    a_r9_zero_flag_shift: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !is_rot && eff_cnt != 5'd0 |=> zf_o == (result_o == 16'h0000));

    a_r10_rotate_keeps_zs: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && is_rot |=> zf_o == $past(zf_i) && sf_o == $past(sf_i));

    a_r12_multi_of_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && eff_cnt > 5'd1 |=> !of_o);

    a_r13_zero_count_copy: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && eff_cnt == 5'd0 |=>
            result_o == ($past(wide_i) ? $past(operand_i) : {8'h00, $past(operand_i[7:0])}));

endmodule

bind sru_top sru_checker u_sru_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .wide_i    (wide_i),
    .cnt_sel_i (cnt_sel_i),
    .cl_i      (cl_i),
    .operand_i (operand_i),
    .zf_i      (zf_i),
    .sf_i      (sf_i),
    .done_o    (done_o),
    .result_o  (result_o),
    .zf_o      (zf_o),
    .sf_o      (sf_o),
    .of_o      (of_o)
);

// File: tb/sru_top_test.sv
// Bench for sru_top: directed corner cases plus seeded random operations,
// each compared with an arithmetic reference model.
module sru_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic        cnt_sel_i = 1'b0;
    logic [7:0]  cl_i = '0;
    logic [15:0] operand_i = '0;
    logic        cf_i = 1'b0, zf_i = 1'b0, sf_i = 1'b0, of_i = 1'b0;
    logic        done_o;
    logic [15:0] result_o;
    logic        cf_o, zf_o, sf_o, of_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sru_top uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wide_i(wide_i),
        .cnt_sel_i(cnt_sel_i), .cl_i(cl_i), .operand_i(operand_i),
        .cf_i(cf_i), .zf_i(zf_i), .sf_i(sf_i), .of_i(of_i),
        .done_o(done_o), .result_o(result_o),
        .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference: arithmetic form of each operation at width w.
    function automatic void model(input int op, input bit wide, input int n,
                                  input longint v, input bit ci, zi, si, oi,
                                  output longint r, output bit co, zo, so, oo);
        int     w    = wide ? 16 : 8;
        longint mask = (64'd1 << w) - 1;
        longint x, y, s;
        int     k;
        bit     rot  = (op >= 3) && (op <= 6);
        bit     left = (op == 0) || (op == 7) || (op == 3) || (op == 5);
        v = v & mask;
        if (n == 0) begin
            r = v; co = ci; zo = zi; so = si; oo = oi;
            return;
        end
        case (op)
            0, 7: begin y = v << n; r = y & mask; co = bit'((y >> w) & 1); end
            1: begin r = v >> n; co = bit'((v >> (n - 1)) & 1); end
            2: begin
                s = v;
                if (((v >> (w - 1)) & 1) == 1) s = v - (64'sd1 << w);
                r = (s >>> n) & mask;
                co = bit'((s >>> (n - 1)) & 1);
            end
            3: begin k = n % w; r = ((v << k) | (v >> (w - k))) & mask; co = bit'(r & 1); end
            4: begin k = n % w; r = ((v >> k) | (v << (w - k))) & mask; co = bit'((r >> (w - 1)) & 1); end
            5: begin
                x = (longint'(ci) << w) | v; k = n % (w + 1);
                y = ((x << k) | (x >> (w + 1 - k))) & ((64'd1 << (w + 1)) - 1);
                r = y & mask; co = bit'((y >> w) & 1);
            end
            default: begin
                x = (longint'(ci) << w) | v; k = n % (w + 1);
                y = ((x >> k) | (x << (w + 1 - k))) & ((64'd1 << (w + 1)) - 1);
                r = y & mask; co = bit'((y >> w) & 1);
            end
        endcase
        zo = rot ? zi : (r == 0);
        so = rot ? si : bit'((r >> (w - 1)) & 1);
        if (n != 1)  oo = 1'b0;
        else if (left) oo = bit'((r >> (w - 1)) & 1) ^ co;
        else oo = bit'((v >> (w - 1)) & 1) ^ bit'((r >> (w - 1)) & 1);
    endfunction

    function automatic string op_req(input int op);
        case (op)
            0, 7: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4: return "R6";
            default: return "R7";
        endcase
    endfunction

    // One operation: drive on a falling edge, check one cycle later, then check hold.
    task automatic run_op(input int op, input bit wide, input bit sel, input int cl,
                          input int v, input bit ci, zi, si, oi);
        longint r; bit co, zo, so, oo; int n;
        logic [15:0] held;
        n = sel ? (cl & 31) : 1;
        model(op, wide, n, longint'(v), ci, zi, si, oi, r, co, zo, so, oo);
        @(negedge clk);
        op_i = 3'(op); wide_i = wide; cnt_sel_i = sel; cl_i = 8'(cl);
        operand_i = 16'(v); cf_i = ci; zf_i = zi; sf_i = si; of_i = oi;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        operand_i = ~operand_i; cf_i = ~cf_i; zf_i = ~zf_i; sf_i = ~sf_i; of_i = ~of_i;
        check("R1 done", done_o, 1);
        if (n == 0) begin
            check("R13 result", result_o, r);
            check("R13 cf", cf_o, co);
            check("R13 zf", zf_o, zo);
            check("R13 sf", sf_o, so);
            check("R13 of", of_o, oo);
        end else begin
            check(wide ? op_req(op) : "R8", result_o, r);
            check({op_req(op), " cf"}, cf_o, co);
            check((op >= 3 && op <= 6) ? "R10 zf" : "R9 zf", zf_o, zo);
            check((op >= 3 && op <= 6) ? "R10 sf" : "R9 sf", sf_o, so);
            check(n == 1 ? "R11 of" : "R12 of", of_o, oo);
        end
        held = result_o;
        @(negedge clk);
        check("R1 done drop", done_o, 0);
        check("R1 hold", result_o, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset done", done_o, 0);
        check("R1 reset result", result_o, 0);
        rst_n = 1'b1;
        // R4 right shift by 3 divides by 8; R3 left shift by 3 multiplies by 8.
        run_op(1, 1, 1, 3, 16'h00F0, 0, 0, 0, 0);
        check("R4 div8", result_o, 16'h001E);
        run_op(0, 1, 1, 3, 16'h0005, 0, 0, 0, 0);
        check("R3 mul8", result_o, 16'h0028);
        // R3 op 7 alias of op 0.
        run_op(7, 0, 0, 0, 8'h40, 0, 0, 0, 0);
        check("R11 of set", of_o, 1);
        // R2 upper count-register bits ignored (0x23 acts as 3).
        run_op(1, 1, 1, 8'h23, 16'h8000, 0, 0, 0, 0);
        check("R2 cl mask", result_o, 16'h1000);
        // R13 zero count.
        run_op(4, 1, 1, 8'h20, 16'hBEEF, 1, 1, 0, 1);
        // R7 byte rotate through carry by 9 returns operand and carry.
        run_op(5, 0, 1, 9, 16'h00A5, 1, 0, 0, 0);
        check("R7 rcl9", result_o, 16'h00A5);
        check("R7 rcl9 cf", cf_o, 1);
        // R5 arithmetic right on negative byte.
        run_op(2, 0, 1, 4, 16'h1290, 0, 0, 0, 0);
        check("R5 sar", result_o, 16'h00F9);
        // R6 rotates, R8 byte mode with upper garbage.
        run_op(3, 0, 0, 0, 16'hFF81, 0, 0, 0, 0);
        check("R6 rol", result_o, 16'h0003);
        run_op(6, 1, 0, 0, 16'h0001, 0, 1, 1, 0);
        for (int i = 0; i < 600; i++) begin
            run_op(int'($urandom % 8), bit'($urandom % 2), bit'($urandom % 4 != 0),
                   int'($urandom % 256), int'($urandom % 65536),
                   bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2));
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'h5EED_0042);
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule